// File: doc/BRIEF.md
# Atomic wide-register byte bridge

This block sits between an 8-bit peripheral bus and three wide registers: a 16-bit register, a 24-bit register and a 32-bit free-running counter. The bus moves one byte per access. A shared bank of three temporary byte latches lets software see each wide register as one consistent value. Stores to the lower bytes are held back and land in the register together with the top byte. Reading the lowest byte freezes the upper bytes for the reads that follow.

Each wide register occupies consecutive byte addresses, lowest byte first. The 16-bit register is at addresses 0 to 1, the 24-bit register at 2 to 4 and the counter at 5 to 8. The three latches are at 9, 10 and 11, where they can be read and written directly. Addresses 12 to 15 are unmapped. The two plain registers also take a parallel load from hardware, and the counter advances by one every clock.

The latches are shared and there is no guard against an interleaved access. If a second sequence starts while one is still open, it overwrites the latches, and the open sequence then returns or stores mixed data. Keeping the accesses in order is left to software.

Top module: `atomic_byte_bridge`

## Requirements
- R1: A bus write to any byte of a wide register other than its top byte stores the byte into latch k, where k is the byte's position inside the register, and leaves the register unchanged.
- R2: A bus write to the top byte of a wide register loads the whole register at that clock edge, from the latches for the lower bytes and from the bus for the top byte. This bus load wins over a hardware load in the same cycle.
- R3: A bus read of byte 0 of a wide register returns the live byte 0. At the same edge, register byte j (j ≥ 1) is copied into latch j−1.
- R4: A bus read of byte j ≥ 1 of a wide register returns latch j−1, not the live register.
- R5: The 16-bit register uses latch 0 only, the 24-bit register uses latches 0 and 1, and the counter uses latches 0 to 2. An access leaves the other latches untouched.
- R6: Latches 0, 1 and 2 are read and written directly at addresses 9, 10 and 11.
- R7: All registers share the latches. A byte-0 read of another register in the middle of a sequence overwrites them, and the later reads of the open sequence return the overwritten values.
- R8: The counter increases by one every cycle. A bus commit to it loads the committed value, and counting resumes from there. Reading it byte 0 first yields the count present at the byte-0 read cycle.
- R9: A read of an unmapped address (12 to 15) returns 0. A write to an unmapped address changes no register and no latch.
- R10: Read data is registered: it shows the result one cycle after the read strobe and holds its value while no read strobe is given.
- R11: Reset clears all wide registers, all latches and the read data to zero.
- R12: When `a_ld` or `b_ld` is high and no bus commit hits that register, the register loads `a_d` or `b_d` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Bus byte address |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| wdata | input | 8 | Bus write byte |
| rdata | output | 8 | Registered read byte |
| a_ld | input | 1 | Hardware load of the 16-bit register |
| a_d | input | 16 | Hardware load value, 16-bit register |
| a_q | output | 16 | Current 16-bit register value |
| b_ld | input | 1 | Hardware load of the 24-bit register |
| b_d | input | 24 | Hardware load value, 24-bit register |
| b_q | output | 24 | Current 24-bit register value |
| cnt_q | output | 32 | Current counter value |

## Verification
The assertions take for granted that the read and write strobes are never high together and that each lasts one cycle. The stimulus never raises both at once and always drops a strobe after one clock. The properties on staging and holding also assume that the hardware load inputs stay low whenever they are not the subject of the check. The bench raises `a_ld` and `b_ld` only in the cycles that test the hardware load and its priority against a bus commit.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int BYTE_W    = 8;
  localparam int NREG      = 3;
  localparam int MAX_BYTES = 4;
  localparam int NTMP      = MAX_BYTES - 1;
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int MAXW      = BYTE_W * MAX_BYTES;
  localparam int CNT_ID    = 2;

  // bytes per wide register, by register index
  function automatic int reg_nbytes(input int id);
    case (id)
      0:       return 2;
      1:       return 3;
      default: return 4;
    endcase
  endfunction

  // lowest byte address of a register: registers are packed back to back
  function automatic int reg_base(input int id);
    int b;
    b = 0;
    for (int k = 0; k < id; k++) b += reg_nbytes(k);
    return b;
  endfunction

  localparam int TMP_BASE = reg_base(NREG);
  localparam int A_W      = BYTE_W * reg_nbytes(0);
  localparam int B_W      = BYTE_W * reg_nbytes(1);
  localparam int C_W      = BYTE_W * reg_nbytes(CNT_ID);

  // full value committed by a top-byte write: latches below, bus byte on top
  function automatic logic [MAXW-1:0] join_commit(input logic [BYTE_W*NTMP-1:0] tmp,
                                                  input logic [BYTE_W-1:0] top,
                                                  input int nbytes);
    logic [MAXW-1:0] v;
    v = '0;
    for (int k = 0; k < NTMP; k++)
      if (k < nbytes - 1) v[BYTE_W*k +: BYTE_W] = tmp[BYTE_W*k +: BYTE_W];
    if (nbytes > 0) v[BYTE_W*(nbytes-1) +: BYTE_W] = top;
    return v;
  endfunction

  // one latch byte by index
  function automatic logic [BYTE_W-1:0] tmp_pick(input logic [BYTE_W*NTMP-1:0] tmp,
                                                 input int idx);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int k = 0; k < NTMP; k++)
      if (k == idx) r = tmp[BYTE_W*k +: BYTE_W];
    return r;
  endfunction

endpackage

// File: rtl/bridge_addr_decode.sv
module bridge_addr_decode
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   reg_hit,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              tmp_hit,
  output logic [IDX_W-1:0]  tmp_idx
);

  always_comb begin
    reg_hit  = '0;
    byte_idx = '0;
    tmp_hit  = 1'b0;
    tmp_idx  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(addr) >= reg_base(i) && int'(addr) < reg_base(i) + reg_nbytes(i)) begin
        reg_hit[i] = 1'b1;
        byte_idx   = IDX_W'(int'(addr) - reg_base(i));
      end
    end
    if (int'(addr) >= TMP_BASE && int'(addr) < TMP_BASE + NTMP) begin
      tmp_hit = 1'b1;
      tmp_idx = IDX_W'(int'(addr) - TMP_BASE);
    end
  end

endmodule

// File: rtl/bridge_tmp_bank.sv
module bridge_tmp_bank
  import bridge_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stage_en,
  input  logic [IDX_W-1:0]       stage_idx,
  input  logic [BYTE_W-1:0]      stage_byte,
  input  logic                   snap_en,
  input  logic [NTMP-1:0]        snap_mask,
  input  logic [BYTE_W*NTMP-1:0] snap_data,
  output logic [BYTE_W*NTMP-1:0] tmp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
    end else begin
      for (int k = 0; k < NTMP; k++) begin
        if (stage_en && stage_idx == IDX_W'(k))
          tmp_q[BYTE_W*k +: BYTE_W] <= stage_byte;
        else if (snap_en && snap_mask[k])
          tmp_q[BYTE_W*k +: BYTE_W] <= snap_data[BYTE_W*k +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/bridge_wide_reg.sv
module bridge_wide_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ld,
  input  logic [W-1:0] bus_val,
  input  logic         hw_ld,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (bus_ld) q <= bus_val;
    else if (hw_ld)  q <= hw_val;
  end

endmodule

// File: rtl/bridge_free_counter.sv
module bridge_free_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ld,
  input  logic [W-1:0] bus_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (bus_ld) q <= bus_val;
    else             q <= q + W'(1);
  end

endmodule

// File: rtl/atomic_byte_bridge.sv
module atomic_byte_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              a_ld,
  input  logic [A_W-1:0]    a_d,
  output logic [A_W-1:0]    a_q,
  input  logic              b_ld,
  input  logic [B_W-1:0]    b_d,
  output logic [B_W-1:0]    b_q,
  output logic [C_W-1:0]    cnt_q
);

  // decoded address
  logic [NREG-1:0]  reg_hit;
  logic [IDX_W-1:0] byte_idx;
  logic             tmp_hit;
  logic [IDX_W-1:0] tmp_idx;

  // named internal events
  logic [NREG-1:0]          commit_ev;
  logic [MAXW-1:0]          commit_bus;
  logic                     stage_ev;
  logic [IDX_W-1:0]         stage_idx;
  logic                     snap_ev;
  logic [NTMP-1:0]          snap_mask;
  logic [BYTE_W*NTMP-1:0]   snap_data;
  logic [BYTE_W*NTMP-1:0]   tmp_q;
  logic [BYTE_W-1:0]        rd_next;
  logic [MAXW-1:0]          reg_val [NREG];
  int                       hit_nbytes;

  bridge_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .reg_hit  (reg_hit),
    .byte_idx (byte_idx),
    .tmp_hit  (tmp_hit),
    .tmp_idx  (tmp_idx)
  );

  always_comb begin
    hit_nbytes = 0;
    for (int i = 0; i < NREG; i++)
      if (reg_hit[i]) hit_nbytes = reg_nbytes(i);
    commit_bus = join_commit(tmp_q, wdata, hit_nbytes);

    commit_ev = '0;
    stage_ev  = 1'b0;
    stage_idx = '0;
    snap_ev   = 1'b0;
    snap_mask = '0;
    snap_data = '0;
    rd_next   = '0;

    if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_hit[i]) begin
          if (int'(byte_idx) == reg_nbytes(i) - 1) begin
            commit_ev[i] = 1'b1;
          end else begin
            stage_ev  = 1'b1;
            stage_idx = byte_idx;
          end
        end
      end
      if (tmp_hit) begin
        stage_ev  = 1'b1;
        stage_idx = tmp_idx;
      end
    end

    if (rd_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_hit[i]) begin
          if (byte_idx == '0) begin
            rd_next = reg_val[i][BYTE_W-1:0];
            snap_ev = 1'b1;
            for (int k = 0; k < NTMP; k++) begin
              if (k < reg_nbytes(i) - 1) begin
                snap_mask[k] = 1'b1;
                snap_data[BYTE_W*k +: BYTE_W] = reg_val[i][BYTE_W*(k+1) +: BYTE_W];
              end
            end
          end else begin
            rd_next = tmp_pick(tmp_q, int'(byte_idx) - 1);
          end
        end
      end
      if (tmp_hit) rd_next = tmp_pick(tmp_q, int'(tmp_idx));
    end
  end

  bridge_tmp_bank u_tmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_en   (stage_ev),
    .stage_idx  (stage_idx),
    .stage_byte (wdata),
    .snap_en    (snap_ev),
    .snap_mask  (snap_mask),
    .snap_data  (snap_data),
    .tmp_q      (tmp_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int W = BYTE_W * reg_nbytes(i);
    logic [W-1:0] q;
    if (i == CNT_ID) begin : g_cnt
      bridge_free_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_ld  (commit_ev[i]),
        .bus_val (commit_bus[W-1:0]),
        .q       (q)
      );
    end else if (i == 0) begin : g_a
      bridge_wide_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_ld  (commit_ev[i]),
        .bus_val (commit_bus[W-1:0]),
        .hw_ld   (a_ld),
        .hw_val  (a_d),
        .q       (q)
      );
    end else begin : g_b
      bridge_wide_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_ld  (commit_ev[i]),
        .bus_val (commit_bus[W-1:0]),
        .hw_ld   (b_ld),
        .hw_val  (b_d),
        .q       (q)
      );
    end
    assign reg_val[i] = MAXW'(q);
  end

  assign a_q   = g_reg[0].q;
  assign b_q   = g_reg[1].q;
  assign cnt_q = g_reg[CNT_ID].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [BYTE_W-1:0]      wdata,
  input logic [BYTE_W-1:0]      rdata,
  input logic                   a_ld,
  input logic [A_W-1:0]         a_q,
  input logic [C_W-1:0]         cnt_q,
  input logic [BYTE_W*NTMP-1:0] tmp_q,
  input logic [NREG-1:0]        commit_ev
);

  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(reg_base(0));
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(reg_base(0) + reg_nbytes(0) - 1);
  localparam logic [ADDR_W-1:0] C_HI  = ADDR_W'(reg_base(CNT_ID) + reg_nbytes(CNT_ID) - 1);
  localparam int                UNMAP = TMP_BASE + NTMP;

  p_stage_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LO && !a_ld) |=> $stable(a_q));

  p_commit_whole_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HI) |=> a_q == {$past(wdata), $past(tmp_q[BYTE_W-1:0])});

  p_low_read_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_LO) |=>
      (tmp_q[BYTE_W-1:0] == $past(a_q[2*BYTE_W-1:BYTE_W]) && rdata == $past(a_q[BYTE_W-1:0])));

  p_high_read_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_HI) |=> rdata == $past(tmp_q[BYTE_W-1:0]));

  p_counter_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == C_HI) |=> cnt_q == $past(cnt_q) + C_W'(1));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) >= UNMAP) |=> rdata == '0);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  p_single_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_ev));

endmodule

bind atomic_byte_bridge bridge_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .a_ld      (a_ld),
  .a_q       (a_q),
  .cnt_q     (cnt_q),
  .tmp_q     (tmp_q),
  .commit_ev (commit_ev)
);

// File: tb/atomic_byte_bridge_test.sv
`timescale 1ns/1ps
module atomic_byte_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        a_ld = 1'b0;
  logic [15:0] a_d = '0;
  logic [15:0] a_q;
  logic        b_ld = 1'b0;
  logic [23:0] b_d = '0;
  logic [23:0] b_q;
  logic [31:0] cnt_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  atomic_byte_bridge uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .a_ld(a_ld), .a_d(a_d), .a_q(a_q),
    .b_ld(b_ld), .b_d(b_d), .b_q(b_q), .cnt_q(cnt_q)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare each read result one cycle after its strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        item_t it;
        @(negedge clk);
        if (sb.size() == 0) begin
          check(1'b0, "scoreboard underflow", 32'(rdata), 32'h0);
        end else begin
          it = sb.pop_front();
          check(rdata == it.exp, it.tag, 32'(rdata), 32'(it.exp));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1;
    logic [31:0] snap;
    item_t it;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(a_q == 16'h0, "R11 a_q reset", 32'(a_q), 32'h0);
    check(b_q == 24'h0, "R11 b_q reset", 32'(b_q), 32'h0);
    check(cnt_q == 32'h0, "R11 cnt_q reset", cnt_q, 32'h0);
    check(rdata == 8'h0, "R11 rdata reset", 32'(rdata), 32'h0);
    rst_n = 1'b1;
    bus_read(4'd9,  8'h00, "R11 latch0 reset");
    bus_read(4'd10, 8'h00, "R11 latch1 reset");
    bus_read(4'd11, 8'h00, "R11 latch2 reset");

    // R1 / R6: low byte staged only
    bus_write(4'd0, 8'h5A);
    check(a_q == 16'h0, "R1 low write does not change A", 32'(a_q), 32'h0);
    bus_read(4'd9, 8'h5A, "R6 R1 latch0 holds staged byte");
    // R2: top byte commits
    bus_write(4'd1, 8'hC3);
    check(a_q == 16'hC35A, "R2 A commit", 32'(a_q), 32'hC35A);

    // R1 / R2: 24-bit register
    bus_write(4'd2, 8'h11);
    bus_write(4'd3, 8'h22);
    check(b_q == 24'h0, "R1 B unchanged while staging", 32'(b_q), 32'h0);
    bus_write(4'd4, 8'h33);
    check(b_q == 24'h332211, "R2 B commit", 32'(b_q), 32'h332211);

    // R3 / R4 / R5: read A low first, only latch0 touched
    bus_read(4'd0, 8'h5A, "R3 A byte0 live");
    bus_read(4'd1, 8'hC3, "R4 A byte1 from latch");
    bus_read(4'd9, 8'hC3, "R3 latch0 snapshot of A");
    bus_read(4'd10, 8'h22, "R5 latch1 untouched by A");

    // R3 / R4 / R12: snapshot survives hardware load
    bus_read(4'd2, 8'h11, "R3 B byte0 live");
    @(negedge clk);
    b_ld = 1'b1; b_d = 24'hAABBCC;
    @(negedge clk);
    b_ld = 1'b0;
    check(b_q == 24'hAABBCC, "R12 B hardware load", 32'(b_q), 32'hAABBCC);
    bus_read(4'd3, 8'h22, "R4 B byte1 frozen");
    bus_read(4'd4, 8'h33, "R4 B byte2 frozen");

    // R7: interleaved access corrupts the shared latches
    bus_read(4'd2, 8'hCC, "R7 B byte0 live");
    bus_read(4'd0, 8'h5A, "R7 A byte0 interleaved");
    bus_read(4'd3, 8'hC3, "R7 B byte1 overwritten by A");
    bus_read(4'd4, 8'hAA, "R7 B byte2 left from B");

    // R6: direct latch write used by commit
    bus_write(4'd9, 8'h77);
    bus_write(4'd1, 8'h99);
    check(a_q == 16'h9977, "R6 commit uses direct latch write", 32'(a_q), 32'h9977);

    // R12: hardware load alone
    @(negedge clk);
    a_ld = 1'b1; a_d = 16'hBEEF;
    @(negedge clk);
    a_ld = 1'b0;
    check(a_q == 16'hBEEF, "R12 A hardware load", 32'(a_q), 32'hBEEF);

    // R2: bus commit wins over hardware load
    @(negedge clk);
    addr = 4'd1; wdata = 8'h55; wr_en = 1'b1; a_ld = 1'b1; a_d = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0; a_ld = 1'b0;
    check(a_q == 16'h5577, "R2 commit beats hardware load", 32'(a_q), 32'h5577);

    // R8: counter increments
    @(negedge clk);
    c1 = cnt_q;
    @(negedge clk);
    check(cnt_q == c1 + 32'd1, "R8 counter step", cnt_q, c1 + 32'd1);

    // R8: snapshot equals count at byte0 read cycle
    @(negedge clk);
    addr = 4'd5; rd_en = 1'b1; snap = cnt_q;
    it.exp = snap[7:0]; it.tag = "R8 counter byte0";
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(4'd6, snap[15:8],  "R8 counter byte1 snapshot");
    bus_read(4'd7, snap[23:16], "R8 counter byte2 snapshot");
    bus_read(4'd8, snap[31:24], "R8 counter byte3 snapshot");

    // R8: bus commit loads the counter, then it resumes
    bus_write(4'd5, 8'h44);
    bus_write(4'd6, 8'h33);
    bus_write(4'd7, 8'h22);
    bus_write(4'd8, 8'h12);
    check(cnt_q == 32'h12223344, "R8 counter commit", cnt_q, 32'h12223344);
    @(negedge clk);
    check(cnt_q == 32'h12223345, "R8 counter resumes", cnt_q, 32'h12223345);

    // R9: unmapped address
    bus_write(4'd9,  8'h01);
    bus_write(4'd10, 8'h02);
    bus_write(4'd11, 8'h03);
    bus_write(4'd12, 8'hFF);
    bus_write(4'd15, 8'hEE);
    check(a_q == 16'h5577, "R9 A unchanged by unmapped write", 32'(a_q), 32'h5577);
    check(b_q == 24'hAABBCC, "R9 B unchanged by unmapped write", 32'(b_q), 32'hAABBCC);
    bus_read(4'd12, 8'h00, "R9 unmapped read is zero");
    bus_read(4'd9,  8'h01, "R9 latch0 unchanged");
    bus_read(4'd10, 8'h02, "R9 latch1 unchanged");
    bus_read(4'd11, 8'h03, "R9 latch2 unchanged");

    // R10: read data holds without a strobe
    repeat (3) @(negedge clk);
    check(rdata == 8'h03, "R10 rdata holds", 32'(rdata), 32'h03);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule